// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the protocol side of a small byte-addressed nonvolatile memory that sits on a two-wire I2C bus. It runs on a fast system clock and oversamples the bus clock (SCL) and data line (SDA). It recognises START and STOP conditions and decodes the control byte, which carries a fixed device code, block-select bits and a read/write flag. It answers with acknowledge bits by pulling SDA low through an open-drain enable. Writes go to an external page buffer as address/data strobes, and a commit pulse is raised when the closing STOP arrives. Reads fetch bytes through a combinational memory read port and shift them out MSB first.

An internal word pointer survives repeated STARTs. A master can therefore set the pointer with a write header and turn straight around into a read. It can also read from wherever the previous access left off, or stream the whole array. While the external write engine reports busy, the block stays completely silent. A master can poll it with bare control bytes until it answers.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: During and after reset the SDA enable is low, and neither the write strobe nor the commit pulse is raised until a transaction occurs.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave changes its SDA enable only while SCL is low.
- R3: The first byte after START is the control byte. Bits 7:4 must equal 4'b1010, bits 3:1 select the block, and bit 0 is the direction (1 = read). With any other code the byte gets no ACK, nothing is written, and the slave ignores the bus until the next START.
- R4: The block-select bits form the upper bits of the array address, above the 8-bit word address. Bit 3 is always ignored. With NUM_BLOCKS=2 bit 2 is also ignored, and with NUM_BLOCKS=4 bits 2:1 are used.
- R5: For every byte received while addressed, the slave pulls SDA low for the whole ninth clock.
- R6: While busy_i is high the slave acknowledges no byte at all, not even a matching control byte, and it drives nothing.
- R7: In a write, the byte after the control byte loads the word pointer. Each later byte gives a one-cycle strobe carrying the pointer and the byte. After each such byte only pointer bits 3:0 increment, wrapping inside the 16-byte page. A STOP after at least one data byte gives a one-cycle commit pulse. A repeated START gives no commit and keeps the pointer.
- R8: In a read, the slave ACKs the control byte and sends the byte at the pointer, MSB first. After a master ACK it sends the next byte. After a master NACK it releases SDA and stays silent until STOP or START.
- R9: Each byte sent advances the full pointer by one, wrapping from the last array address to 0. A current-address read therefore returns the byte after the last one read.
- R10: An SDA enable change caused by a falling SCL happens no sooner than HOLD_CYC clock cycles after that falling edge is detected.
- R11: A START in the middle of a byte discards the partial byte and restarts control-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_i | input | 1 | High while a self-timed write cycle is running |
| mem_addr_o | output | 8+log2(NUM_BLOCKS) | Read address (the word pointer) |
| mem_rdata_i | input | 8 | Byte at mem_addr_o, combinational |
| pb_wr_o | output | 1 | One-cycle strobe for a received data byte |
| pb_addr_o | output | 8+log2(NUM_BLOCKS) | Array address for the strobed byte |
| pb_data_o | output | 8 | Strobed data byte |
| pb_commit_o | output | 1 | One-cycle pulse asking the buffer to program its contents |

## Verification
The checker watches on every cycle that the SDA enable only rises while the synchronized SCL is low, and never in the cycle right after a detected fall. It also checks that the enable stays off in the idle and ignore states, that a commit follows a detected STOP, that write strobes come only on SCL falls, and that the read address holds steady while a byte is shifted out. The scenarios alone show the values: block-select decoding, page rollover with the last 16 bytes kept, pointer carry-over into random and current-address reads, array wrap, busy polling, and recovery from an aborted byte.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } i2cs_state_e;

  typedef enum logic [1:0] {
    BK_CTRL, BK_WADDR, BK_WDATA
  } i2cs_kind_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_ok_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_pipe;
  logic [2:0] scl_p;
  logic [2:0] sda_p;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  // two flops of synchronization plus one history flop; idle bus is high
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_s     = scl_p[1];
  assign sda_s     = sda_p[1];
  assign scl_rise  =  scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] &  scl_p[2];
  assign start_det =  scl_p[1] &  scl_p[2] &  sda_p[2] & ~sda_p[1];
  assign stop_det  =  scl_p[1] &  scl_p[2] & ~sda_p[2] &  sda_p[1];
endmodule

// File: rtl/i2cs_hold.sv
`timescale 1ns/1ps
module i2cs_hold #(
  parameter int HOLD_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  output logic apply
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (scl_fall)          cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign apply = (cnt_q == ONE);
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
  import i2cs_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int HOLD_CYC   = 30,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int AW = 8 + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          busy_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          pb_wr_o,
  output logic [AW-1:0] pb_addr_o,
  output logic [7:0]    pb_data_o,
  output logic          pb_commit_o
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  logic rst_ok_n, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, apply;

  i2cs_sync sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_ok_n(rst_ok_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_hold #(.HOLD_CYC(HOLD_CYC)) hold_i (
    .clk(clk), .rst_n(rst_ok_n), .scl_fall(scl_fall), .apply(apply)
  );

  i2cs_state_e   st_q, st_d;
  i2cs_kind_e    kind_q, kind_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d, txreg_q, txreg_d;
  logic [AW-1:0] ptr_q, ptr_d, pbaddr_q, pbaddr_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [7:0]    pbdata_q, pbdata_d;
  logic          go_tx_q, go_tx_d, mack_q, mack_d, drive_q, drive_d;
  logic          oe_q, oe_d, pend_q, pend_d, pbwr_q, pbwr_d, commit_q, commit_d;

  always_comb begin
    st_d = st_q;       kind_d = kind_q;   bitcnt_d = bitcnt_q;
    shreg_d = shreg_q; txreg_d = txreg_q; ptr_d = ptr_q;
    blk_d = blk_q;     go_tx_d = go_tx_q; mack_d = mack_q;
    drive_d = drive_q; pend_d = pend_q;
    pbaddr_d = pbaddr_q; pbdata_d = pbdata_q;
    pbwr_d = 1'b0;     commit_d = 1'b0;
    oe_d = apply ? drive_q : oe_q;

    if (start_det) begin
      st_d = ST_RX; kind_d = BK_CTRL; bitcnt_d = 4'd0;
      drive_d = 1'b0; oe_d = 1'b0; pend_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; drive_d = 1'b0; oe_d = 1'b0;
      commit_d = pend_q; pend_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            bitcnt_d = 4'd0;
            if (busy_i) begin
              st_d = ST_SKIP;
            end else begin
              unique case (kind_q)
                BK_CTRL: begin
                  if (shreg_q[7:4] == DEV_CODE) begin
                    st_d = ST_ACK; drive_d = 1'b1;
                    blk_d = shreg_q[BW:1];
                    ptr_d = {shreg_q[BW:1], ptr_q[7:0]};
                    go_tx_d = shreg_q[0];
                    kind_d = BK_WADDR;
                  end else begin
                    st_d = ST_SKIP;
                  end
                end
                BK_WADDR: begin
                  st_d = ST_ACK; drive_d = 1'b1; go_tx_d = 1'b0;
                  ptr_d = {blk_q, shreg_q};
                  kind_d = BK_WDATA;
                end
                default: begin
                  st_d = ST_ACK; drive_d = 1'b1; go_tx_d = 1'b0;
                  pbwr_d = 1'b1; pbaddr_d = ptr_q; pbdata_d = shreg_q;
                  ptr_d = {ptr_q[AW-1:4], ptr_q[3:0] + 4'd1};
                  pend_d = 1'b1;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_d = 4'd0;
            if (go_tx_q) begin
              st_d = ST_TX; txreg_d = mem_rdata_i;
              ptr_d = ptr_q + PTR_ONE; drive_d = ~mem_rdata_i[7];
            end else begin
              st_d = ST_RX; drive_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              st_d = ST_MACK; drive_d = 1'b0;
            end else begin
              txreg_d = {txreg_q[6:0], 1'b0};
              drive_d = ~txreg_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            bitcnt_d = 4'd0;
            if (mack_q) begin
              st_d = ST_TX; txreg_d = mem_rdata_i;
              ptr_d = ptr_q + PTR_ONE; drive_d = ~mem_rdata_i[7];
            end else begin
              st_d = ST_SKIP; drive_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      st_q <= ST_IDLE;   kind_q <= BK_CTRL; bitcnt_q <= 4'd0;
      shreg_q <= 8'd0;   txreg_q <= 8'd0;   ptr_q <= '0;
      blk_q <= '0;       go_tx_q <= 1'b0;   mack_q <= 1'b0;
      drive_q <= 1'b0;   oe_q <= 1'b0;      pend_q <= 1'b0;
      pbwr_q <= 1'b0;    pbaddr_q <= '0;    pbdata_q <= 8'd0;
      commit_q <= 1'b0;
    end else begin
      st_q <= st_d;       kind_q <= kind_d;   bitcnt_q <= bitcnt_d;
      shreg_q <= shreg_d; txreg_q <= txreg_d; ptr_q <= ptr_d;
      blk_q <= blk_d;     go_tx_q <= go_tx_d; mack_q <= mack_d;
      drive_q <= drive_d; oe_q <= oe_d;       pend_q <= pend_d;
      pbwr_q <= pbwr_d;   pbaddr_q <= pbaddr_d; pbdata_q <= pbdata_d;
      commit_q <= commit_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = ptr_q;
  assign pb_wr_o     = pbwr_q;
  assign pb_addr_o   = pbaddr_q;
  assign pb_data_o   = pbdata_q;
  assign pb_commit_o = commit_q;
endmodule

// File: rtl/i2cs_chk.sv
`timescale 1ns/1ps
module i2cs_chk
  import i2cs_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_fall,
  input logic          stop_det,
  input i2cs_state_e   st_q,
  input logic          sda_oe_o,
  input logic          pb_wr_o,
  input logic          pb_commit_o,
  input logic [AW-1:0] mem_addr_o
);
  // R2
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);

  // R10
  oe_hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_fall));

  // R7
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_commit_o |-> $past(stop_det));

  // R7
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr_o |-> $past(scl_fall));

  // R3
  silent_when_unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_SKIP) |-> !sda_oe_o);

  // R8
  addr_steady_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && $past(st_q) == ST_TX) |-> $stable(mem_addr_o));
endmodule

bind i2c_eeprom_slave i2cs_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_ok_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .st_q(st_q), .sda_oe_o(sda_oe_o),
  .pb_wr_o(pb_wr_o), .pb_commit_o(pb_commit_o), .mem_addr_o(mem_addr_o)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
  localparam int NB = 4;
  localparam int AW = 10;
  localparam int HOLD = 30;
  localparam int Q = 25;
  localparam int BUSY_CYC = 2500;

  // {block_sel[2:0], word[7:0], data[7:0], expected_array_addr[9:0]}
  localparam logic [28:0] VEC [0:4] = '{
    {3'b000, 8'h05, 8'h3C, 10'h005},
    {3'b001, 8'h80, 8'hA5, 10'h180},
    {3'b010, 8'hFF, 8'h5A, 10'h2FF},
    {3'b111, 8'h00, 8'hC3, 10'h300},
    {3'b100, 8'h7E, 8'h81, 10'h07E}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, busy;
  logic sda_oe, pb_wr, pb_commit;
  logic [AW-1:0] maddr, pb_addr;
  logic [7:0] rdata, pb_data;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [0:(1<<AW)-1];
  assign rdata = mem[maddr];

  i2c_eeprom_slave #(.NUM_BLOCKS(NB), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .mem_addr_o(maddr), .mem_rdata_i(rdata),
    .pb_wr_o(pb_wr), .pb_addr_o(pb_addr), .pb_data_o(pb_data),
    .pb_commit_o(pb_commit)
  );

  int ncmp = 0, nerr = 0, ncommit = 0, nwr = 0, busy_cnt = 0, pn = 0;
  logic [AW-1:0] pa [0:63];
  logic [7:0]    pd [0:63];
  logic [7:0]    rbuf [0:15];
  logic          acks_ok;
  bit            done = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 4));
  endfunction

  // page buffer and write-engine model
  assign busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (pb_wr) begin
      if (pn < 64) begin pa[pn] = pb_addr; pd[pn] = pb_data; pn = pn + 1; end
      nwr = nwr + 1;
    end
    if (pb_commit) begin
      for (int i = 0; i < pn; i++) mem[pa[i]] = pd[i];
      pn = 0; ncommit = ncommit + 1; busy_cnt = BUSY_CYC;
    end
  end

  // SDA enable timing monitor
  int since = 0, min_hold = 1000, hi_chg = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (prev_scl && !scl_m) since = 0; else since = since + 1;
    prev_scl = scl_m;
    if (rst_n && sda_oe !== prev_oe) begin
      if (scl_m) hi_chg = hi_chg + 1;
      else if (since < min_hold) min_hold = since;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    ncmp++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic wq; repeat (Q) @(posedge clk); #2; endtask
  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask
  task automatic bus_start;
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask
  task automatic bus_stop;
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_line; wq(); scl_m = 0; wq();
  endtask
  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0; wq();
    end
    bit_out(~m_ack);
  endtask

  // random / sequential read of n bytes from (blk, word)
  task automatic rd_seq(input logic [2:0] blk, input logic [7:0] w, input int n);
    logic a1, a2, a3;
    logic [7:0] b;
    bus_start(); send_byte({4'b1010, blk, 1'b0}, a1); send_byte(w, a2);
    bus_start(); send_byte({4'b1010, blk, 1'b1}, a3);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b); rbuf[i] = b;
    end
    bus_stop();
    acks_ok = a1 & a2 & a3;
  endtask

  task automatic wait_ready(output logic first_nack);
    logic a;
    first_nack = 1'b0;
    for (int p = 0; p < 40; p++) begin
      bus_start(); send_byte(8'hA0, a); bus_stop();
      if (p == 0) first_nack = ~a;
      if (a) break;
    end
  endtask

  initial begin
    logic a0, a1, a2, fnack;
    logic [2:0] blk;
    logic [7:0] w, d, b;
    logic [9:0] ea;
    int c0, w0;
    logic [7:0] exp_pg [0:15];

    for (int i = 0; i < (1 << AW); i++) mem[i] = pat(i);
    rst_n = 0; scl_m = 1; sda_m = 1;
    repeat (5) @(posedge clk); #2;
    chk(sda_oe == 0 && pb_wr == 0 && pb_commit == 0, "R1 reset outputs",
        {sda_oe, pb_wr, pb_commit}, 0);
    rst_n = 1; wq();
    chk(sda_oe == 0 && sda_line == 1 && ncommit == 0, "R1 after reset",
        {sda_oe, sda_line}, 1);

    // table walk: byte write, poll, random read back
    for (int v = 0; v < 5; v++) begin
      {blk, w, d, ea} = VEC[v];
      c0 = ncommit;
      bus_start(); send_byte({4'b1010, blk, 1'b0}, a0); send_byte(w, a1); send_byte(d, a2);
      bus_stop(); wq();
      chk(a0 & a1 & a2, "R5 ack write bytes", {a0, a1, a2}, 3'b111);
      chk(ncommit == c0 + 1, "R7 commit on stop", ncommit, c0 + 1);
      chk(mem[ea] == d, "R4 block select address", mem[ea], d);
      wait_ready(fnack);
      chk(fnack, "R6 no ack while busy", fnack, 1);
      c0 = ncommit;
      rd_seq(blk, w, 1);
      chk(acks_ok && rbuf[0] == d, "R8 random read data", rbuf[0], d);
      chk(ncommit == c0, "R7 repeated start no commit", ncommit, c0);
    end

    // R3: wrong device code ignored
    c0 = ncommit; w0 = nwr;
    bus_start(); send_byte(8'h50, a0); send_byte(8'hA0, a1); send_byte(8'h34, a2); bus_stop(); wq();
    chk(!a0 && !a1 && !a2, "R3 no ack for wrong code", {a0, a1, a2}, 0);
    chk(ncommit == c0 && nwr == w0, "R3 nothing written", nwr, w0);

    // R7: page write of 18 bytes from word 0x1E in block 1, rollover in page
    c0 = ncommit; acks_ok = 1;
    bus_start(); send_byte(8'hA2, a0); send_byte(8'h1E, a1); acks_ok = a0 & a1;
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h60 + 8'(k), a2); acks_ok &= a2;
      exp_pg[(14 + k) & 15] = 8'h60 + 8'(k);
    end
    bus_stop(); wq();
    chk(acks_ok && ncommit == c0 + 1, "R7 page write commit", ncommit, c0 + 1);
    wait_ready(fnack);
    chk(fnack, "R6 poll nack after page write", fnack, 1);
    rd_seq(3'b001, 8'h10, 16);
    for (int j = 0; j < 16; j++)
      chk(rbuf[j] == exp_pg[j], "R7 page rollover keeps last 16", rbuf[j], exp_pg[j]);

    // R9: current-address read continues after 0x11F; R8: release after NACK
    bus_start(); send_byte(8'hA3, a0); recv_byte(1'b0, b);
    chk(a0 && b == mem[10'h120], "R9 current address read", b, mem[10'h120]);
    sda_m = 1; wq(); scl_m = 1; wq(); a1 = sda_line; wq(); scl_m = 0; wq();
    chk(a1 == 1 && sda_oe == 0, "R8 released after master nack", a1, 1);
    bus_stop();

    // R9: wrap from last array address to 0
    rd_seq(3'b011, 8'hFF, 2);
    chk(acks_ok && rbuf[0] == mem[10'h3FF], "R9 last address", rbuf[0], mem[10'h3FF]);
    chk(rbuf[1] == mem[10'h000], "R9 wrap to zero", rbuf[1], mem[10'h000]);

    // R11: START in the middle of a byte restarts reception
    bus_start(); bit_out(1); bit_out(0); bit_out(1);
    bus_start(); send_byte(8'hA1, a0); recv_byte(1'b0, b); bus_stop();
    chk(a0 && b == mem[10'h001], "R11 abort then current read", b, mem[10'h001]);

    chk(min_hold >= HOLD && min_hold < 1000, "R10 output hold after scl fall", min_hold, HOLD);
    chk(hi_chg == 0, "R2 sda enable changed with scl high", hi_chg, 0);
    report();
  end
endmodule